// File: doc/BRIEF.md
# Interrupt Entry Controller

This block sits beside a processor core and decides, cycle by cycle, whether the core is sent into a non-maskable interrupt handler, into one of six maskable interrupt handlers, or back from a handler. It owns the processor status word (PSW), two context save banks (one for the non-maskable path, one for the maskable path) and a 32-bit exception cause register. When an entry or return is performed it raises a one-cycle redirect strobe together with the address the core must fetch from next.

The core supplies its current PC, a ready strobe that permits entry, and a return strobe. Software-visible PSW updates from the core arrive through a masked write port. Non-maskable requests are captured on a rising edge and at most one is held. Maskable requests are captured as sticky pending flags that remain set until their entry is performed. While a handler runs, the PSW flags hold back further requests, and those requests are taken once a return clears the flags.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its idle state: `redirect` low, `redirect_pc` 0, `psw` 0x20, `cause` 0, both save banks 0 and all pending requests cleared.
- R2: The PSW bit layout is Z=0, S=1, OV=2, CY=3, SAT=4, ID=5, EP=6, NP=7. A write through `psw_we`/`psw_wdata` takes effect at the next edge, stores only bits 7:0, and bits 31:8 of `psw` always read as zero.
- R3: A rising edge on `nmi_in` sampled at one edge, with NP clear and `core_ready` high at the next edge, performs a non-maskable entry at that next edge: `redirect` high for one cycle with `redirect_pc` 0x10, `cur_pc` and the old `psw` copied to `nmi_save_pc`/`nmi_save_psw`, NP and ID set, EP cleared and the other PSW bits unchanged.
- R4: Every entry keeps `cause[31:16]` and replaces `cause[15:0]` with the entry code: 0x10 for the non-maskable path and the vector address for a maskable source.
- R5: While NP is set, a captured non-maskable request is held and retried every cycle. Further rising edges that arrive while one is held are dropped, so exactly one entry follows once NP clears.
- R6: A maskable request is held, not lost, while NP or ID is set, and it is taken on the first eligible cycle after both are clear.
- R7: A maskable entry copies `cur_pc` and the old `psw` to `irq_save_pc`/`irq_save_psw`, sets ID, clears EP, leaves NP unchanged and does not touch the non-maskable bank.
- R8: Maskable source i (`irq_in[i]`, i = 0..5) redirects to 0x80 + 0x10*i, so sources 0..5 use 0x80, 0x90, 0xA0, 0xB0, 0xC0 and 0xD0.
- R9: Reset outranks the non-maskable request, which outranks all maskable ones. Among maskable requests pending together the lowest index wins, and the others stay pending.
- R10: A high `ret_req` at an edge restores `redirect_pc` and `psw` from the non-maskable bank if NP is set, otherwise from the maskable bank, and pulses `redirect`. No entry is performed in that cycle, and a held request may enter at the following edge.
- R11: No entry is performed at an edge where `core_ready` is low. Requests stay pending until an edge with `core_ready` high.
- R12: The non-maskable input is edge sensitive, so holding `nmi_in` high causes only one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_in | input | 6 | Maskable requests, bit i is source i |
| core_ready | input | 1 | Core can accept an entry this cycle |
| ret_req | input | 1 | Return-from-handler strobe |
| cur_pc | input | 32 | PC of the core, saved on entry |
| psw_we | input | 1 | PSW write enable |
| psw_wdata | input | 32 | PSW write data, masked to bits 7:0 |
| redirect | output | 1 | One-cycle strobe: core must fetch from `redirect_pc` |
| redirect_pc | output | 32 | Target address of the latest redirect |
| psw | output | 32 | Processor status word |
| nmi_save_pc | output | 32 | PC saved on non-maskable entry |
| nmi_save_psw | output | 32 | PSW saved on non-maskable entry |
| irq_save_pc | output | 32 | PC saved on maskable entry |
| irq_save_psw | output | 32 | PSW saved on maskable entry |
| cause | output | 32 | Exception cause register |

## Verification
The hardest situation to reach is a queue of work held back by the PSW flags: a non-maskable request retried under NP with a second edge that must be dropped, and three maskable sources pending in the same cycle behind a non-maskable entry. The stimulus raises `nmi_in` and several `irq_in` bits in one cycle, then issues a return after each redirect. The scoreboard expects the sequence 0x10, then return, 0x90, return, 0xA0, return, 0xC0, and checks the cause code and save bank after each entry. Separate phases hold requests back with `core_ready` low and with ID set, and keep `nmi_in` high over many cycles.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    // PSW bit positions
    localparam int PSW_Z   = 0;
    localparam int PSW_S   = 1;
    localparam int PSW_OV  = 2;
    localparam int PSW_CY  = 3;
    localparam int PSW_SAT = 4;
    localparam int PSW_ID  = 5;
    localparam int PSW_EP  = 6;
    localparam int PSW_NP  = 7;

    localparam logic [31:0] PSW_WMASK = 32'h0000_00FF;
    localparam logic [31:0] PSW_RESET = 32'h0000_0020;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_RET  = 2'd1,
        ACT_NMI  = 2'd2,
        ACT_IRQ  = 2'd3
    } irq_act_e;

    function automatic logic [31:0] irq_vector(input logic [31:0] base,
                                               input logic [31:0] step,
                                               input logic [31:0] idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int N_IRQ = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_in,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             nmi_clr,
    input  logic [N_IRQ-1:0] irq_clr,
    output logic             nmi_pend,
    output logic [N_IRQ-1:0] irq_pend
);

    logic nmi_prev;
    logic nmi_rise;

    assign nmi_rise = nmi_in & ~nmi_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
            irq_pend <= '0;
        end else begin
            nmi_prev <= nmi_in;
            nmi_pend <= (nmi_pend & ~nmi_clr) | nmi_rise;
            irq_pend <= (irq_pend | irq_in) & ~irq_clr;
        end
    end

    // R5: a held NMI stays pending until it is entered
    a_r5_nmi_held: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && !nmi_clr) |=> nmi_pend);

    // R6: no maskable pending flag is lost without its entry
    a_r6_irq_held: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(irq_pend) & ~$past(irq_clr) & ~irq_pend) == '0));

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_entry_pkg::*;
#(
    parameter int N_IRQ = 6,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             nmi_pend,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic             psw_np,
    input  logic             psw_id,
    input  logic             core_ready,
    input  logic             ret_req,
    output irq_act_e         act,
    output logic [N_IRQ-1:0] irq_grant,
    output logic [IDX_W-1:0] irq_idx
);

    logic [N_IRQ:0] seen;
    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N_IRQ; i++) begin : g_chain
            assign irq_grant[i]  = irq_pend[i] & ~seen[i];
            assign seen[i+1]     = seen[i] | irq_pend[i];
        end
    endgenerate

    always_comb begin
        irq_idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (irq_pend[i]) irq_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (ret_req)
            act = ACT_RET;
        else if (core_ready && nmi_pend && !psw_np)
            act = ACT_NMI;
        else if (core_ready && seen[N_IRQ] && !psw_np && !psw_id)
            act = ACT_IRQ;
        else
            act = ACT_NONE;
    end

endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
    import irq_entry_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          N_IRQ        = 6,
    parameter logic [31:0] NMI_VEC      = 32'h10,
    parameter logic [31:0] IRQ_VEC_BASE = 32'h80,
    parameter logic [31:0] VEC_STEP     = 32'h10,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int HALF  = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst,
    input  irq_act_e        act,
    input  logic [IDX_W-1:0] irq_idx,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            psw_we,
    input  logic [XLEN-1:0] psw_wdata,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] psw,
    output logic [XLEN-1:0] nmi_save_pc,
    output logic [XLEN-1:0] nmi_save_psw,
    output logic [XLEN-1:0] irq_save_pc,
    output logic [XLEN-1:0] irq_save_psw,
    output logic [XLEN-1:0] cause
);

    localparam logic [XLEN-1:0] WMASK = XLEN'(PSW_WMASK);
    localparam logic [XLEN-1:0] NP_B  = XLEN'(1) << PSW_NP;
    localparam logic [XLEN-1:0] ID_B  = XLEN'(1) << PSW_ID;
    localparam logic [XLEN-1:0] EP_B  = XLEN'(1) << PSW_EP;

    logic [XLEN-1:0] irq_vec;
    assign irq_vec = XLEN'(irq_vector(IRQ_VEC_BASE, VEC_STEP, 32'(irq_idx)));

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect     <= 1'b0;
            redirect_pc  <= '0;
            psw          <= XLEN'(PSW_RESET);
            nmi_save_pc  <= '0;
            nmi_save_psw <= '0;
            irq_save_pc  <= '0;
            irq_save_psw <= '0;
            cause        <= '0;
        end else begin
            redirect <= 1'b0;
            unique case (act)
                ACT_RET: begin
                    redirect <= 1'b1;
                    if (psw[PSW_NP]) begin
                        redirect_pc <= nmi_save_pc;
                        psw         <= nmi_save_psw & WMASK;
                    end else begin
                        redirect_pc <= irq_save_pc;
                        psw         <= irq_save_psw & WMASK;
                    end
                end
                ACT_NMI: begin
                    redirect     <= 1'b1;
                    redirect_pc  <= XLEN'(NMI_VEC);
                    nmi_save_pc  <= cur_pc;
                    nmi_save_psw <= psw;
                    psw          <= (psw | NP_B | ID_B) & ~EP_B;
                    cause        <= {cause[XLEN-1:HALF], HALF'(NMI_VEC)};
                end
                ACT_IRQ: begin
                    redirect     <= 1'b1;
                    redirect_pc  <= irq_vec;
                    irq_save_pc  <= cur_pc;
                    irq_save_psw <= psw;
                    psw          <= (psw | ID_B) & ~EP_B;
                    cause        <= {cause[XLEN-1:HALF], irq_vec[HALF-1:0]};
                end
                default: begin
                    if (psw_we) psw <= psw_wdata & WMASK;
                end
            endcase
        end
    end

    // R3: NMI entry flags and vector
    a_r3_nmi_entry: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_NMI) |=> (redirect && psw[PSW_NP] && psw[PSW_ID]
                              && !psw[PSW_EP] && redirect_pc == XLEN'(NMI_VEC)));

    // R7: maskable entry leaves NP alone, sets ID, clears EP
    a_r7_irq_flags: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_IRQ) |=> (redirect && psw[PSW_ID] && !psw[PSW_EP]
                              && psw[PSW_NP] == $past(psw[PSW_NP])));

    // R4: upper half of cause survives every entry
    a_r4_cause_upper: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_NMI || act == ACT_IRQ)
        |=> (cause[XLEN-1:HALF] == $past(cause[XLEN-1:HALF])));

    // R2: bits above the write mask never become set
    a_r2_psw_upper: assert property (@(posedge clk) disable iff (rst)
        (psw & ~WMASK) == '0);

    // R10: a return always redirects
    a_r10_ret_pulse: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_RET) |=> redirect);

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          N_IRQ        = 6,
    parameter logic [31:0] NMI_VEC      = 32'h10,
    parameter logic [31:0] IRQ_VEC_BASE = 32'h80,
    parameter logic [31:0] VEC_STEP     = 32'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_in,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             core_ready,
    input  logic             ret_req,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             psw_we,
    input  logic [XLEN-1:0]  psw_wdata,
    output logic             redirect,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [XLEN-1:0]  psw,
    output logic [XLEN-1:0]  nmi_save_pc,
    output logic [XLEN-1:0]  nmi_save_psw,
    output logic [XLEN-1:0]  irq_save_pc,
    output logic [XLEN-1:0]  irq_save_psw,
    output logic [XLEN-1:0]  cause
);

    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    irq_act_e         act;
    logic             nmi_pend;
    logic [N_IRQ-1:0] irq_pend;
    logic [N_IRQ-1:0] irq_grant;
    logic [IDX_W-1:0] irq_idx;
    logic             nmi_clr;
    logic [N_IRQ-1:0] irq_clr;

    assign nmi_clr = (act == ACT_NMI);
    assign irq_clr = (act == ACT_IRQ) ? irq_grant : '0;

    irq_req_capture #(.N_IRQ(N_IRQ)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .nmi_in   (nmi_in),
        .irq_in   (irq_in),
        .nmi_clr  (nmi_clr),
        .irq_clr  (irq_clr),
        .nmi_pend (nmi_pend),
        .irq_pend (irq_pend)
    );

    irq_prio_sel #(.N_IRQ(N_IRQ)) u_prio (
        .nmi_pend   (nmi_pend),
        .irq_pend   (irq_pend),
        .psw_np     (psw[PSW_NP]),
        .psw_id     (psw[PSW_ID]),
        .core_ready (core_ready),
        .ret_req    (ret_req),
        .act        (act),
        .irq_grant  (irq_grant),
        .irq_idx    (irq_idx)
    );

    irq_ctx_regs #(
        .XLEN         (XLEN),
        .N_IRQ        (N_IRQ),
        .NMI_VEC      (NMI_VEC),
        .IRQ_VEC_BASE (IRQ_VEC_BASE),
        .VEC_STEP     (VEC_STEP)
    ) u_ctx (
        .clk          (clk),
        .rst          (rst),
        .act          (act),
        .irq_idx      (irq_idx),
        .cur_pc       (cur_pc),
        .psw_we       (psw_we),
        .psw_wdata    (psw_wdata),
        .redirect     (redirect),
        .redirect_pc  (redirect_pc),
        .psw          (psw),
        .nmi_save_pc  (nmi_save_pc),
        .nmi_save_psw (nmi_save_psw),
        .irq_save_pc  (irq_save_pc),
        .irq_save_psw (irq_save_psw),
        .cause        (cause)
    );

    // R11: without core_ready and without a return there is no redirect
    a_r11_wait_ready: assert property (@(posedge clk) disable iff (rst)
        (!core_ready && !ret_req) |=> !redirect);

    // R9: a maskable grant is exactly one source
    a_r9_one_grant: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_IRQ) |-> ($countones(irq_clr) == 1 && !nmi_clr));

endmodule

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;

    typedef struct {
        logic [31:0] pc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_in = 1'b0;
    logic [5:0]  irq_in = '0;
    logic        core_ready = 1'b1;
    logic        ret_req = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        psw_we = 1'b0;
    logic [31:0] psw_wdata = '0;
    logic        redirect;
    logic [31:0] redirect_pc, psw, nmi_save_pc, nmi_save_psw;
    logic [31:0] irq_save_pc, irq_save_psw, cause;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    irq_entry_ctrl u0 (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .irq_in(irq_in),
        .core_ready(core_ready), .ret_req(ret_req), .cur_pc(cur_pc),
        .psw_we(psw_we), .psw_wdata(psw_wdata), .redirect(redirect),
        .redirect_pc(redirect_pc), .psw(psw), .nmi_save_pc(nmi_save_pc),
        .nmi_save_psw(nmi_save_psw), .irq_save_pc(irq_save_pc),
        .irq_save_psw(irq_save_psw), .cause(cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_redirect(input logic [31:0] pc, input string tag);
        exp_t e;
        e.pc  = pc;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic write_psw(input logic [31:0] v);
        psw_we = 1'b1;
        psw_wdata = v;
        step(1);
        psw_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Monitor: every redirect pulse pops one expected target
    always @(negedge clk) begin
        if (!rst && redirect) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3/R10 unexpected redirect actual=%h expected=none", redirect_pc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (redirect_pc !== e.pc) begin
                    fails++;
                    $display("FAIL %s redirect actual=%h expected=%h", e.tag, redirect_pc, e.pc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 psw", psw, 32'h20);
        chk("R1 redirect", {31'b0, redirect}, 32'h0);
        chk("R1 redirect_pc", redirect_pc, 32'h0);
        chk("R1 cause", cause, 32'h0);
        chk("R1 nmi_save_pc", nmi_save_pc, 32'h0);

        // R2 masked PSW write
        write_psw(32'hDEAD_BE5F);
        chk("R2 masked write", psw, 32'h5F);
        write_psw(32'hFFFF_FF0F);
        chk("R2 upper zero", psw, 32'h0F);

        // R3 / R4 NMI entry
        cur_pc = 32'h1234;
        nmi_in = 1'b1;
        expect_redirect(32'h10, "R3");
        step(1);
        nmi_in = 1'b0;
        step(1);
        chk("R3 redirect", {31'b0, redirect}, 32'h1);
        chk("R3 nmi_save_pc", nmi_save_pc, 32'h1234);
        chk("R3 nmi_save_psw", nmi_save_psw, 32'h0F);
        chk("R3 psw", psw, 32'hAF);
        chk("R4 cause", cause, 32'h10);
        step(1);
        chk("R3 single pulse", {31'b0, redirect}, 32'h0);

        // R5 NMI held under NP, second edge dropped
        cur_pc = 32'h2000;
        nmi_in = 1'b1; step(1);
        nmi_in = 1'b0; step(1);
        nmi_in = 1'b1; step(1);
        nmi_in = 1'b0; step(6);
        chk("R5 held psw", psw, 32'hAF);
        chk("R5 held bank", nmi_save_pc, 32'h1234);
        ret_req = 1'b1;
        expect_redirect(32'h1234, "R10");
        expect_redirect(32'h10, "R5");
        step(1);
        ret_req = 1'b0;
        chk("R10 nmi bank psw", psw, 32'h0F);
        step(1);
        chk("R5 retaken bank", nmi_save_pc, 32'h2000);
        chk("R5 retaken psw", psw, 32'hAF);
        ret_req = 1'b1;
        expect_redirect(32'h2000, "R10");
        step(1);
        ret_req = 1'b0;
        chk("R10 restore", psw, 32'h0F);
        step(5);
        chk("R5 dropped edge", psw, 32'h0F);

        // R11 core_ready gating, R7/R8 maskable entry
        core_ready = 1'b0;
        cur_pc = 32'h3000;
        irq_in = 6'b001000;
        step(1);
        irq_in = '0;
        step(5);
        chk("R11 not taken", psw, 32'h0F);
        core_ready = 1'b1;
        expect_redirect(32'hB0, "R8");
        step(1);
        chk("R7 irq_save_pc", irq_save_pc, 32'h3000);
        chk("R7 irq_save_psw", irq_save_psw, 32'h0F);
        chk("R7 psw", psw, 32'h2F);
        chk("R7 nmi bank kept", nmi_save_pc, 32'h2000);
        chk("R4 irq cause", cause, 32'hB0);

        // R6 held while ID set
        irq_in = 6'b100000;
        step(1);
        irq_in = '0;
        step(4);
        chk("R6 held by ID", cause, 32'hB0);
        write_psw(32'h0F);
        expect_redirect(32'hD0, "R8");
        step(1);
        chk("R6 taken", cause, 32'hD0);
        chk("R6 saved psw", irq_save_psw, 32'h0F);
        chk("R7 psw after", psw, 32'h2F);

        // R9 priority, R6 held by NP
        write_psw(32'h0);
        cur_pc = 32'h4000;
        nmi_in = 1'b1;
        irq_in = 6'b010110;
        expect_redirect(32'h10, "R9");
        step(1);
        nmi_in = 1'b0;
        irq_in = '0;
        step(1);
        chk("R9 nmi first", cause, 32'h10);
        chk("R9 psw", psw, 32'hA0);
        step(3);
        chk("R6 held by NP", cause, 32'h10);
        for (int k = 0; k < 3; k++) begin
            logic [31:0] code;
            code = (k == 0) ? 32'h90 : (k == 1) ? 32'hA0 : 32'hC0;
            ret_req = 1'b1;
            expect_redirect(32'h4000, "R10");
            expect_redirect(code, "R9");
            step(1);
            ret_req = 1'b0;
            chk("R10 restored psw", psw, 32'h0);
            step(1);
            chk("R9 lowest first", cause, code);
            chk("R7 save pc", irq_save_pc, 32'h4000);
            step(2);
        end
        ret_req = 1'b1;
        expect_redirect(32'h4000, "R10");
        step(1);
        ret_req = 1'b0;
        chk("R10 irq bank psw", psw, 32'h0);
        step(4);

        // R12 level NMI gives one entry
        nmi_in = 1'b1;
        expect_redirect(32'h10, "R12");
        step(8);
        chk("R12 entered", psw, 32'hA0);
        ret_req = 1'b1;
        expect_redirect(32'h4000, "R10");
        step(1);
        ret_req = 1'b0;
        step(5);
        nmi_in = 1'b0;
        step(2);
        chk("R12 single entry", psw, 32'h0);
        chk("R12 queue drained", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule